// File: doc/BRIEF.md
# Double-Buffered Neighbour Transfer Register Bank

This block is the small communication register bank that sits between adjacent processors in a linear processor array. It keeps two banks of equal size. The local functional units read only the active bank. The left and right neighbours deposit values only into the other bank, the shadow bank. A switch command exchanges the two roles. A single bank-select bit flips, no data is copied, and a value a neighbour delivered becomes readable locally on the cycle after the switch.

Before a task is scheduled, the program loads a selection mask naming the registers that the next task will consume. Each accepted neighbour write sets a per-register arrival flag. A switch request is held off (stall high) while any selected register has not arrived, so the switch also synchronises producer and consumer tasks. A configuration word assigns every shadow register either to the left neighbour or to the right neighbour. A write from the neighbour that does not own the register is dropped and raises a sticky error flag.

Top module: `xfer_regbank`

## Requirements
- R1: While and after reset, `active_bank` is 0, every register reads as zero, `switch_stall` is low and `err_flag` is low. The ownership map resets to indices below NREG/2 owned by the left neighbour and the rest owned by the right neighbour.
- R2: Two independent combinational read ports return the active-bank register selected by `rd_idx_a` and `rd_idx_b`.
- R3: An accepted neighbour write goes to the shadow bank. It does not change any value seen on the read ports until a switch completes, and after that switch the written value is readable at its index.
- R4: With no pending selected register, a switch request completes at the next rising edge and `active_bank` toggles. `active_bank` changes at no other time.
- R5: While `switch_req` is high and any register whose bit is 1 in the current mask has no arrival flag, `switch_stall` is high and the banks do not swap. The swap happens at the first edge after the last selected register has been written. `switch_stall` is never high without `switch_req`.
- R6: A completed switch clears all arrival flags and empties the mask, so an immediately following switch request does not stall.
- R7: `cfg_left_own` bit i = 1 gives register i to the left neighbour (`lw_*`), and bit i = 0 gives it to the right neighbour (`rw_*`). A `cfg_valid` pulse loads the map.
- R8: A neighbour write to a register that neighbour does not own leaves the register unchanged and sets `err_flag`, which then stays high until reset.
- R9: A neighbour write in the same cycle as a completing switch lands in the new shadow bank (the previously active one) and sets that register's arrival flag.
- R10: A `mask_valid` pulse in the same cycle as a completing switch installs the new mask instead of emptying it.
- R11: A switch exchanges the banks without copying: two switches with no writes between them restore the values previously read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | IW | Read port A register index |
| rd_data_a | output | DW | Active-bank data at rd_idx_a |
| rd_idx_b | input | IW | Read port B register index |
| rd_data_b | output | DW | Active-bank data at rd_idx_b |
| lw_valid | input | 1 | Left neighbour write strobe |
| lw_idx | input | IW | Left neighbour write index |
| lw_data | input | DW | Left neighbour write data |
| rw_valid | input | 1 | Right neighbour write strobe |
| rw_idx | input | IW | Right neighbour write index |
| rw_data | input | DW | Right neighbour write data |
| cfg_valid | input | 1 | Load the ownership map |
| cfg_left_own | input | NREG | Ownership map, bit=1 left-owned |
| mask_valid | input | 1 | Load the selection mask |
| mask_sel | input | NREG | Registers the next task awaits |
| switch_req | input | 1 | Request a bank exchange |
| switch_stall | output | 1 | Request held: awaited data missing |
| active_bank | output | 1 | Which physical bank is active |
| err_flag | output | 1 | Sticky partition-violation flag |

## Verification
The swap is tried with an empty mask, with a two-register mask whose members arrive from different neighbours in separate cycles, and with a mask loaded on the same edge as a switch. These cases separate an immediate grant, a grant that waits for the last arrival, and the precedence between mask loading and mask clearing. Writes are sent to owned and non-owned indices both before and after the ownership map changes, and one write collides with a granted switch. This shows whether data reaches the correct physical bank and whether rejected data stays out. A pair of back-to-back switches with no writes between them separates a real exchange from a copy.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic {
    SIDE_RIGHT = 1'b0,
    SIDE_LEFT  = 1'b1
  } side_e;

endpackage

// File: rtl/xfer_port_gate.sv
module xfer_port_gate
  import xfer_pkg::*;
#(
  parameter int    NREG = 16,
  parameter int    IW   = 4,
  parameter side_e SIDE = SIDE_LEFT
) (
  input  logic            valid,
  input  logic [IW-1:0]   idx,
  input  logic [NREG-1:0] left_own,
  output logic            accept,
  output logic            reject
);

  logic in_range;
  logic owner_bit;
  logic owned;

  assign in_range  = ({1'b0, idx} < (IW+1)'(NREG));
  assign owner_bit = in_range ? left_own[idx] : 1'b0;

  generate
    if (SIDE == SIDE_LEFT) begin : g_left
      assign owned = in_range & owner_bit;
    end else begin : g_right
      assign owned = in_range & ~owner_bit;
    end
  endgenerate

  assign accept = valid & owned;
  assign reject = valid & ~owned;

endmodule

// File: rtl/xfer_sync_ctl.sv
module xfer_sync_ctl #(
  parameter int NREG = 16,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mask_valid,
  input  logic [NREG-1:0] mask_sel,
  input  logic            switch_req,
  input  logic            l_acc,
  input  logic [IW-1:0]   l_idx,
  input  logic            r_acc,
  input  logic [IW-1:0]   r_idx,
  input  logic            l_rej,
  input  logic            r_rej,
  output logic            fire,
  output logic            stall,
  output logic            bank_q,
  output logic            err_q,
  output logic [NREG-1:0] mask_q,
  output logic [NREG-1:0] flags_q
);

  logic [NREG-1:0] hits;
  logic [NREG-1:0] pending;
  logic            blocked;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      hits[i] = (l_acc && (l_idx == IW'(i))) || (r_acc && (r_idx == IW'(i)));
    end
  end

  assign pending = mask_q & ~flags_q;
  assign blocked = |pending;
  assign fire    = switch_req & ~blocked;
  assign stall   = switch_req & blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q  <= 1'b0;
      err_q   <= 1'b0;
      mask_q  <= '0;
      flags_q <= '0;
    end else begin
      if (fire) begin
        bank_q  <= ~bank_q;
        flags_q <= hits;
        mask_q  <= mask_valid ? mask_sel : '0;
      end else begin
        flags_q <= flags_q | hits;
        if (mask_valid) mask_q <= mask_sel;
      end
      if (l_rej || r_rej) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/xfer_bank_store.sv
module xfer_bank_store #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int IW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_l,
  input  logic [IW-1:0] wi_l,
  input  logic [DW-1:0] wd_l,
  input  logic          we_r,
  input  logic [IW-1:0] wi_r,
  input  logic [DW-1:0] wd_r,
  input  logic          wr_bank,
  input  logic          rd_bank,
  input  logic [IW-1:0] ra_a,
  output logic [DW-1:0] rd_a,
  input  logic [IW-1:0] ra_b,
  output logic [DW-1:0] rd_b
);

  localparam int NBANK = 2;

  logic [NBANK-1:0][DW-1:0] port_a_w;
  logic [NBANK-1:0][DW-1:0] port_b_w;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] regs [NREG];
    logic          sel_here;

    assign sel_here = (wr_bank == 1'(b));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else begin
        if (we_l && sel_here) regs[wi_l] <= wd_l;
        if (we_r && sel_here) regs[wi_r] <= wd_r;
      end
    end

    assign port_a_w[b] = regs[ra_a];
    assign port_b_w[b] = regs[ra_b];
  end

  assign rd_a = port_a_w[rd_bank];
  assign rd_b = port_b_w[rd_bank];

endmodule

// File: rtl/xfer_regbank.sv
module xfer_regbank
  import xfer_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IW-1:0]   rd_idx_a,
  output logic [DW-1:0]   rd_data_a,
  input  logic [IW-1:0]   rd_idx_b,
  output logic [DW-1:0]   rd_data_b,
  input  logic            lw_valid,
  input  logic [IW-1:0]   lw_idx,
  input  logic [DW-1:0]   lw_data,
  input  logic            rw_valid,
  input  logic [IW-1:0]   rw_idx,
  input  logic [DW-1:0]   rw_data,
  input  logic            cfg_valid,
  input  logic [NREG-1:0] cfg_left_own,
  input  logic            mask_valid,
  input  logic [NREG-1:0] mask_sel,
  input  logic            switch_req,
  output logic            switch_stall,
  output logic            active_bank,
  output logic            err_flag
);

  localparam int NLEFT = NREG / 2;
  localparam logic [NREG-1:0] OWN_RST = {{(NREG-NLEFT){1'b0}}, {NLEFT{1'b1}}};

  logic [NREG-1:0] own_q;
  logic            l_acc, l_rej, r_acc, r_rej;
  logic            fire;
  logic            bank_q;
  logic            wr_bank;
  logic [NREG-1:0] mask_q;
  logic [NREG-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (rst)            own_q <= OWN_RST;
    else if (cfg_valid) own_q <= cfg_left_own;
  end

  xfer_port_gate #(.NREG(NREG), .IW(IW), .SIDE(SIDE_LEFT)) gate_l_i (
    .valid(lw_valid), .idx(lw_idx), .left_own(own_q),
    .accept(l_acc), .reject(l_rej)
  );

  xfer_port_gate #(.NREG(NREG), .IW(IW), .SIDE(SIDE_RIGHT)) gate_r_i (
    .valid(rw_valid), .idx(rw_idx), .left_own(own_q),
    .accept(r_acc), .reject(r_rej)
  );

  xfer_sync_ctl #(.NREG(NREG), .IW(IW)) ctl_i (
    .clk(clk), .rst(rst),
    .mask_valid(mask_valid), .mask_sel(mask_sel),
    .switch_req(switch_req),
    .l_acc(l_acc), .l_idx(lw_idx), .r_acc(r_acc), .r_idx(rw_idx),
    .l_rej(l_rej), .r_rej(r_rej),
    .fire(fire), .stall(switch_stall), .bank_q(bank_q), .err_q(err_flag),
    .mask_q(mask_q), .flags_q(flags_q)
  );

  // a write that coincides with a granted switch targets the bank that is about to become the shadow
  assign wr_bank = fire ? bank_q : ~bank_q;

  xfer_bank_store #(.NREG(NREG), .DW(DW), .IW(IW)) store_i (
    .clk(clk), .rst(rst),
    .we_l(l_acc), .wi_l(lw_idx), .wd_l(lw_data),
    .we_r(r_acc), .wi_r(rw_idx), .wd_r(rw_data),
    .wr_bank(wr_bank), .rd_bank(bank_q),
    .ra_a(rd_idx_a), .rd_a(rd_data_a),
    .ra_b(rd_idx_b), .rd_b(rd_data_b)
  );

  assign active_bank = bank_q;

endmodule

// File: rtl/xfer_regbank_chk.sv
module xfer_regbank_chk #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int IW   = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            switch_req,
  input logic            switch_stall,
  input logic            active_bank,
  input logic            err_flag,
  input logic            mask_valid,
  input logic [NREG-1:0] mask_q,
  input logic [IW-1:0]   rd_idx_a,
  input logic [DW-1:0]   rd_data_a
);

  AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    switch_stall |-> switch_req); // R5

  AST_SWAP_ON_GRANT: assert property (@(posedge clk) disable iff (rst)
    (switch_req && !switch_stall) |=> (active_bank != $past(active_bank))); // R4

  AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
    !(switch_req && !switch_stall) |=> $stable(active_bank)); // R4

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R8

  AST_MASK_EMPTIED: assert property (@(posedge clk) disable iff (rst)
    (switch_req && !switch_stall && !mask_valid) |=> (mask_q == '0)); // R6

  AST_SHADOW_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    !(switch_req && !switch_stall) |=> (!$stable(rd_idx_a) || $stable(rd_data_a))); // R3

endmodule

bind xfer_regbank xfer_regbank_chk #(.NREG(NREG), .DW(DW), .IW(IW)) chk_i (
  .clk(clk), .rst(rst),
  .switch_req(switch_req), .switch_stall(switch_stall),
  .active_bank(active_bank), .err_flag(err_flag),
  .mask_valid(mask_valid), .mask_q(mask_q),
  .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a)
);

// File: tb/xfer_regbank_tb_top.sv
`timescale 1ns/1ps
module xfer_regbank_tb_top;

  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int IW   = 4;

  logic            clk = 1'b0;
  logic            rst;
  logic [IW-1:0]   rd_idx_a, rd_idx_b;
  logic [DW-1:0]   rd_data_a, rd_data_b;
  logic            lw_valid, rw_valid;
  logic [IW-1:0]   lw_idx, rw_idx;
  logic [DW-1:0]   lw_data, rw_data;
  logic            cfg_valid, mask_valid, switch_req;
  logic [NREG-1:0] cfg_left_own, mask_sel;
  logic            switch_stall, active_bank, err_flag;

  always #2.5 clk = ~clk;

  xfer_regbank #(.NREG(NREG), .DW(DW), .IW(IW)) dut_i (
    .clk(clk), .rst(rst),
    .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
    .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
    .lw_valid(lw_valid), .lw_idx(lw_idx), .lw_data(lw_data),
    .rw_valid(rw_valid), .rw_idx(rw_idx), .rw_data(rw_data),
    .cfg_valid(cfg_valid), .cfg_left_own(cfg_left_own),
    .mask_valid(mask_valid), .mask_sel(mask_sel),
    .switch_req(switch_req), .switch_stall(switch_stall),
    .active_bank(active_bank), .err_flag(err_flag)
  );

  typedef struct {
    bit          port_b;
    int          idx;
    logic [31:0] val;
    string       tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  int n_chk = 0;
  int n_err = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: applies one queued read per falling edge and compares
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      if (it.port_b) rd_idx_b = IW'(it.idx);
      else           rd_idx_a = IW'(it.idx);
      #1;
      check(it.tag, it.port_b ? rd_data_b : rd_data_a, it.val);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic exp_rd(bit pb, int idx, logic [31:0] v, string tag);
    rd_item_t it;
    it.port_b = pb; it.idx = idx; it.val = v; it.tag = tag;
    sb_q.push_back(it);
    while (sb_q.size() != 0) @(posedge clk);
    #1;
  endtask

  task automatic lwrite(int idx, logic [31:0] d);
    lw_valid = 1'b1; lw_idx = IW'(idx); lw_data = d;
    tick();
    lw_valid = 1'b0;
  endtask

  task automatic rwrite(int idx, logic [31:0] d);
    rw_valid = 1'b1; rw_idx = IW'(idx); rw_data = d;
    tick();
    rw_valid = 1'b0;
  endtask

  task automatic load_mask(logic [NREG-1:0] m);
    mask_valid = 1'b1; mask_sel = m;
    tick();
    mask_valid = 1'b0;
  endtask

  task automatic quick_switch(logic exp_bank, string tag);
    switch_req = 1'b1;
    @(negedge clk);
    check({tag, " stall"}, 32'(switch_stall), 32'h0);
    @(posedge clk); #1;
    switch_req = 1'b0;
    check({tag, " bank"}, 32'(active_bank), 32'(exp_bank));
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    rd_idx_a = '0; rd_idx_b = '0;
    lw_valid = 0; rw_valid = 0; lw_idx = '0; rw_idx = '0; lw_data = '0; rw_data = '0;
    cfg_valid = 0; cfg_left_own = '0; mask_valid = 0; mask_sel = '0; switch_req = 0;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R1 reset state
    check("R1 bank", 32'(active_bank), 32'h0);
    check("R1 err", 32'(err_flag), 32'h0);
    check("R1 stall", 32'(switch_stall), 32'h0);
    exp_rd(0, 5, 32'h0, "R1 read zero");

    // R2 R3 R7: default map, left owns 2, right owns 12; hidden until switch
    lw_valid = 1; lw_idx = 4'd2; lw_data = 32'hA1A1_0002;
    rw_valid = 1; rw_idx = 4'd12; rw_data = 32'hB1B1_000C;
    tick();
    lw_valid = 0; rw_valid = 0;
    exp_rd(0, 2, 32'h0, "R3 shadow hidden a");
    exp_rd(1, 12, 32'h0, "R3 shadow hidden b");
    quick_switch(1'b1, "R4 empty mask");
    exp_rd(0, 2, 32'hA1A1_0002, "R2 R3 port a after switch");
    exp_rd(1, 12, 32'hB1B1_000C, "R2 R7 port b after switch");

    // R11 swap without copy
    quick_switch(1'b0, "R11 swap1");
    exp_rd(0, 2, 32'h0, "R11 old bank");
    quick_switch(1'b1, "R11 swap2");
    exp_rd(0, 2, 32'hA1A1_0002, "R11 restored");

    // R5 stall until masked registers 3 (left) and 9 (right) arrive
    load_mask(16'h0208);
    switch_req = 1'b1;
    @(negedge clk);
    check("R5 stall none arrived", 32'(switch_stall), 32'h1);
    @(posedge clk); #1;
    lwrite(3, 32'hC3C3_0003);
    @(negedge clk);
    check("R5 stall one arrived", 32'(switch_stall), 32'h1);
    check("R5 no swap while stalled", 32'(active_bank), 32'h1);
    @(posedge clk); #1;
    rwrite(9, 32'hC9C9_0009);
    @(negedge clk);
    check("R5 stall released", 32'(switch_stall), 32'h0);
    @(posedge clk); #1;
    switch_req = 1'b0;
    check("R5 swapped", 32'(active_bank), 32'h0);
    exp_rd(0, 3, 32'hC3C3_0003, "R5 data 3");
    exp_rd(1, 9, 32'hC9C9_0009, "R5 data 9");

    // R6 mask emptied after switch
    quick_switch(1'b1, "R6 no stall after grant");
    exp_rd(0, 3, 32'h0, "R6 other bank idx3");

    // R8 right writes left-owned idx 3: dropped, sticky error
    rwrite(3, 32'hDEAD_0003);
    check("R8 err set", 32'(err_flag), 32'h1);
    quick_switch(1'b0, "R8 switch");
    exp_rd(0, 3, 32'hC3C3_0003, "R8 data unchanged");
    repeat (3) tick();
    check("R8 err sticky", 32'(err_flag), 32'h1);

    // R7 reassign idx 3 to the right neighbour
    cfg_valid = 1; cfg_left_own = 16'h00F7;
    tick();
    cfg_valid = 0;
    lw_valid = 1; lw_idx = 4'd3; lw_data = 32'hBAD0_0003;
    rw_valid = 1; rw_idx = 4'd3; rw_data = 32'hE3E3_0003;
    tick();
    lw_valid = 0; rw_valid = 0;
    lwrite(4, 32'hE4E4_0004);
    quick_switch(1'b1, "R7 switch");
    exp_rd(0, 3, 32'hE3E3_0003, "R7 right owns 3");
    exp_rd(1, 4, 32'hE4E4_0004, "R7 left owns 4");

    // R9 write colliding with a granted switch lands in the new shadow bank
    switch_req = 1'b1;
    lw_valid = 1; lw_idx = 4'd5; lw_data = 32'hF5F5_0005;
    @(negedge clk);
    check("R9 grant", 32'(switch_stall), 32'h0);
    @(posedge clk); #1;
    switch_req = 1'b0; lw_valid = 0;
    check("R9 bank", 32'(active_bank), 32'h0);
    exp_rd(0, 5, 32'h0, "R9 not in active");
    load_mask(16'h0020);
    quick_switch(1'b1, "R9 flag kept");
    exp_rd(0, 5, 32'hF5F5_0005, "R9 data");

    // R10 mask load together with a granted switch
    switch_req = 1'b1;
    mask_valid = 1'b1; mask_sel = 16'h0040;
    @(posedge clk); #1;
    mask_valid = 1'b0;
    check("R10 bank", 32'(active_bank), 32'h0);
    @(negedge clk);
    check("R10 new mask stalls", 32'(switch_stall), 32'h1);
    @(posedge clk); #1;
    lwrite(6, 32'h6666_0006);
    @(negedge clk);
    check("R10 released", 32'(switch_stall), 32'h0);
    @(posedge clk); #1;
    switch_req = 1'b0;
    check("R10 swapped", 32'(active_bank), 32'h1);
    exp_rd(0, 6, 32'h6666_0006, "R10 data");

    // R1 second reset clears everything
    rst = 1'b1;
    tick();
    rst = 1'b0;
    tick();
    check("R1 err cleared", 32'(err_flag), 32'h0);
    check("R1 bank cleared", 32'(active_bank), 32'h0);
    exp_rd(1, 3, 32'h0, "R1 data cleared");

    finish_run();
  end

endmodule